// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Timing Generator

This block produces the control waveforms for one chip-select region of an asynchronous static memory bus. A request carries a read or write command, an address and write data. Once the request is accepted, the block drives the address onto the bus. It then lowers chip select and the active strobe, each after its own programmed delay, and holds each one low for its own programmed width. The access ends when a programmed total length, counted in clock cycles, has run out. At that point a one-cycle completion pulse appears, and for a read the captured data word appears with it.

Four timing lanes each carry an independent delay and width: the write strobe, chip select during a write, the read strobe, and chip select during a read. Delay, width and total length are held as compact bit-weighted codes, and the block expands them internally. Hold time is not programmed. Whatever part of the total length is left after a strobe rises becomes idle release time. Two mode bits set how data moves. One picks whether read data is sampled when chip select rises or when the read strobe rises. The other picks whether chip select or the write strobe frames the interval in which write data is driven.

Top module: `asram_timing_gen`

## Requirements
- R1: After reset, with a legal configuration, chip select, read strobe and write strobe are high, the write-data enable is low, the completion pulse is low and the request-ready output is high.
- R2: A 6-bit delay code c expands to 128*c[5] + c[4:0] cycles. Counting the first bus cycle after acceptance as cycle 0, a lane goes low first in the cycle equal to its expanded delay.
- R3: A 7-bit width code c expands to 256*c[6] + c[5:0] cycles, and a lane stays low for exactly that many consecutive cycles.
- R4: A 9-bit length code c expands to 256*c[8:7] + c[6:0] cycles. An access keeps the block busy for exactly that many cycles. The completion pulse is then high for exactly one cycle, and the block is ready again in the same cycle.
- R5: If any lane's width code is zero, the configuration-error output is high, ready is low and no access starts.
- R6: If delay plus width exceeds the total length for any lane, the configuration-error output is high and no access starts. Delay plus width equal to the length is legal.
- R7: With the read-sample mode bit at 1, read data is the bus input value in the last low cycle of read chip select. With the bit at 0, it is the value in the last low cycle of the read strobe.
- R8: The write-data enable is high exactly while the framing signal is low. That signal is write chip select when the write-frame mode bit is 1 and the write strobe when the bit is 0. While the enable is high, the data output equals the request's write data.
- R9: A read uses the read lanes and never lowers the write strobe. A write uses the write lanes and never lowers the read strobe.
- R10: The bus address stays stable through the whole access. Ready is low while busy, and a request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every interval is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we_setup | input | 6 | Write strobe delay code |
| cfg_csw_setup | input | 6 | Write chip-select delay code |
| cfg_rd_setup | input | 6 | Read strobe delay code |
| cfg_csr_setup | input | 6 | Read chip-select delay code |
| cfg_we_pulse | input | 7 | Write strobe width code |
| cfg_csw_pulse | input | 7 | Write chip-select width code |
| cfg_rd_pulse | input | 7 | Read strobe width code |
| cfg_csr_pulse | input | 7 | Read chip-select width code |
| cfg_cycle | input | 9 | Total access length code |
| cfg_rd_on_cs | input | 1 | 1: sample read data as chip select rises; 0: as the read strobe rises |
| cfg_wr_on_cs | input | 1 | 1: chip select frames write data; 0: the write strobe frames it |
| cfg_err | output | 1 | Configuration is illegal |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Request is accepted when valid and ready |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Bus address |
| mem_dout | output | DATA_W | Bus write data |
| mem_dout_oe | output | 1 | Bus write data enable |
| mem_din | input | DATA_W | Bus read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default widths of 16 address and 16 data bits. The timing code widths are fixed by the encoding, so the full code range is reachable. Vectors set the high-weight bits of the delay, width and length codes, giving accesses of 261 and 512 cycles. Other vectors place the end of the read strobe and the end of chip select on different cycles, and a bus input that changes every cycle shows which edge sampled the data. Further cases cover a lane that ends exactly on the last cycle of the access, and lanes of differing width for the two write-framing modes.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int SET_CODE_W = 6;
  localparam int PUL_CODE_W = 7;
  localparam int CYC_CODE_W = 9;

  // expanded widths: 128+31, 256+63, 768+127
  localparam int SET_W = 8;
  localparam int PUL_W = 9;
  localparam int CYC_W = 10;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    LN_WE  = 2'd0,
    LN_CSW = 2'd1,
    LN_RD  = 2'd2,
    LN_CSR = 2'd3
  } lane_e;

  function automatic logic [SET_W-1:0] expand_setup(input logic [SET_CODE_W-1:0] c);
    logic [SET_W-1:0] v;
    v = {3'b000, c[4:0]};
    if (c[5]) v = v + SET_W'(128);
    return v;
  endfunction

  function automatic logic [PUL_W-1:0] expand_pulse(input logic [PUL_CODE_W-1:0] c);
    logic [PUL_W-1:0] v;
    v = {3'b000, c[5:0]};
    if (c[6]) v = v + PUL_W'(256);
    return v;
  endfunction

  function automatic logic [CYC_W-1:0] expand_cycle(input logic [CYC_CODE_W-1:0] c);
    return {c[8:7], 8'h00} + {3'b000, c[6:0]};
  endfunction

endpackage

// File: rtl/asram_cfg_check.sv
module asram_cfg_check
  import asram_pkg::*;
(
  input  logic [LANES-1:0][SET_CODE_W-1:0] set_codes,
  input  logic [LANES-1:0][PUL_CODE_W-1:0] pul_codes,
  input  logic [CYC_CODE_W-1:0]            cyc_code,
  output logic [LANES-1:0][SET_W-1:0]      lane_setup,
  output logic [LANES-1:0][CYC_W-1:0]      lane_end,
  output logic [CYC_W-1:0]                 cyc_len,
  output logic                             cfg_err
);

  logic [LANES-1:0] lane_bad;

  assign cyc_len = expand_cycle(cyc_code);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PUL_W-1:0] pul;
    assign lane_setup[g] = expand_setup(set_codes[g]);
    assign pul           = expand_pulse(pul_codes[g]);
    assign lane_end[g]   = CYC_W'(lane_setup[g]) + CYC_W'(pul);
    assign lane_bad[g]   = (pul == '0) || (lane_end[g] > cyc_len);
  end

  assign cfg_err = |lane_bad;

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CYC_W-1:0] cyc_len,
  output logic             busy_q,
  output logic             busy_nxt,
  output logic [CYC_W-1:0] cnt_nxt,
  output logic             last,
  output logic             done_q
);

  logic [CYC_W-1:0] cnt_q;

  assign last = busy_q && (cnt_q == (cyc_len - CYC_W'(1)));

  always_comb begin
    busy_nxt = busy_q;
    cnt_nxt  = cnt_q;
    if (start) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_nxt = 1'b0;
        cnt_nxt  = '0;
      end else begin
        cnt_nxt  = cnt_q + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      cnt_q  <= cnt_nxt;
      done_q <= last;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < cyc_len)); // R4

endmodule

// File: rtl/asram_lane.sv
module asram_lane
  import asram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_nxt,
  input  logic             busy_nxt,
  input  logic [CYC_W-1:0] cnt_nxt,
  input  logic [SET_W-1:0] setup,
  input  logic [CYC_W-1:0] lane_end,
  output logic             lane_n_q,
  output logic             rise
);

  logic lane_n_d;
  logic in_window;

  assign in_window = (cnt_nxt >= CYC_W'(setup)) && (cnt_nxt < lane_end);
  assign lane_n_d  = !(busy_nxt && en_nxt && in_window);
  assign rise      = !lane_n_q && lane_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_n_q <= 1'b1;
    else        lane_n_q <= lane_n_d;
  end

  AST_RISE_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> lane_n_q); // R3

endmodule

// File: rtl/asram_timing_gen.sv
module asram_timing_gen
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_we_setup,
  input  logic [5:0]        cfg_csw_setup,
  input  logic [5:0]        cfg_rd_setup,
  input  logic [5:0]        cfg_csr_setup,
  input  logic [6:0]        cfg_we_pulse,
  input  logic [6:0]        cfg_csw_pulse,
  input  logic [6:0]        cfg_rd_pulse,
  input  logic [6:0]        cfg_csr_pulse,
  input  logic [8:0]        cfg_cycle,
  input  logic              cfg_rd_on_cs,
  input  logic              cfg_wr_on_cs,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n
);

  localparam int IWE  = int'(LN_WE);
  localparam int ICSW = int'(LN_CSW);
  localparam int IRD  = int'(LN_RD);
  localparam int ICSR = int'(LN_CSR);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // configuration decode
  logic [LANES-1:0][SET_CODE_W-1:0] set_codes;
  logic [LANES-1:0][PUL_CODE_W-1:0] pul_codes;
  logic [LANES-1:0][SET_W-1:0]      lane_setup;
  logic [LANES-1:0][CYC_W-1:0]      lane_end;
  logic [CYC_W-1:0]                 cyc_len;

  assign set_codes[IWE]  = cfg_we_setup;
  assign set_codes[ICSW] = cfg_csw_setup;
  assign set_codes[IRD]  = cfg_rd_setup;
  assign set_codes[ICSR] = cfg_csr_setup;
  assign pul_codes[IWE]  = cfg_we_pulse;
  assign pul_codes[ICSW] = cfg_csw_pulse;
  assign pul_codes[IRD]  = cfg_rd_pulse;
  assign pul_codes[ICSR] = cfg_csr_pulse;

  asram_cfg_check u_cfg (
    .set_codes  (set_codes),
    .pul_codes  (pul_codes),
    .cyc_code   (cfg_cycle),
    .lane_setup (lane_setup),
    .lane_end   (lane_end),
    .cyc_len    (cyc_len),
    .cfg_err    (cfg_err)
  );

  // sequencing
  logic             start;
  logic             busy_q;
  logic             busy_nxt;
  logic [CYC_W-1:0] cnt_nxt;
  logic             last;
  logic             done_q;

  assign req_ready = !busy_q && !cfg_err && rst_sync_n;
  assign start     = req_valid && req_ready;

  asram_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .cyc_len  (cyc_len),
    .busy_q   (busy_q),
    .busy_nxt (busy_nxt),
    .cnt_nxt  (cnt_nxt),
    .last     (last),
    .done_q   (done_q)
  );

  // request registers
  logic              op_write_q;
  logic              op_write_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign op_write_nxt = start ? req_write : op_write_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_write_q <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else if (start) begin
      op_write_q <= req_write;
      addr_q     <= req_addr;
      wdata_q    <= req_wdata;
    end
  end

  // timing lanes
  logic [LANES-1:0] lane_n;
  logic [LANES-1:0] lane_rise;
  logic [LANES-1:0] lane_en;

  assign lane_en[IWE]  = op_write_nxt;
  assign lane_en[ICSW] = op_write_nxt;
  assign lane_en[IRD]  = !op_write_nxt;
  assign lane_en[ICSR] = !op_write_nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    asram_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en_nxt   (lane_en[g]),
      .busy_nxt (busy_nxt),
      .cnt_nxt  (cnt_nxt),
      .setup    (lane_setup[g]),
      .lane_end (lane_end[g]),
      .lane_n_q (lane_n[g]),
      .rise     (lane_rise[g])
    );
  end

  // read data capture on the selected rising edge
  logic              cap_en;
  logic [DATA_W-1:0] rdata_q;

  assign cap_en = lane_rise[cfg_rd_on_cs ? ICSR : IRD];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (cap_en)  rdata_q <= mem_din;
  end

  // bus outputs
  logic wr_frame_n;

  assign wr_frame_n  = cfg_wr_on_cs ? lane_n[ICSW] : lane_n[IWE];
  assign mem_cs_n    = op_write_q ? lane_n[ICSW] : lane_n[ICSR];
  assign mem_rd_n    = lane_n[IRD];
  assign mem_wr_n    = lane_n[IWE];
  assign mem_dout_oe = op_write_q && !wr_frame_n;
  assign mem_dout    = wdata_q;
  assign mem_addr    = addr_q;
  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;

  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_err && !busy_q) |=> !busy_q); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_q && !last) |=> $stable(mem_addr)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_rd_n || mem_wr_n)); // R9
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dout_oe |-> (op_write_q && busy_q)); // R8

endmodule

// File: tb/asram_timing_gen_tb_top.sv
module asram_timing_gen_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] we_s, csw_s, rd_s, csr_s;
  logic [6:0] we_p, csw_p, rd_p, csr_p;
  logic [8:0] cyc;
  logic rd_on_cs, wr_on_cs;
  logic cfg_err;
  logic req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic req_ready, rsp_done;
  logic [DATA_W-1:0] rsp_rdata, mem_dout, mem_din;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_dout_oe, mem_cs_n, mem_rd_n, mem_wr_n;

  asram_timing_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_setup(we_s), .cfg_csw_setup(csw_s), .cfg_rd_setup(rd_s), .cfg_csr_setup(csr_s),
    .cfg_we_pulse(we_p), .cfg_csw_pulse(csw_p), .cfg_rd_pulse(rd_p), .cfg_csr_pulse(csr_p),
    .cfg_cycle(cyc), .cfg_rd_on_cs(rd_on_cs), .cfg_wr_on_cs(wr_on_cs), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe), .mem_din(mem_din),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus: op, mode, strobe/cs codes, length code; expected busy length
  typedef struct packed {
    logic       wr;
    logic       mode;
    logic [5:0] s_str;
    logic [6:0] p_str;
    logic [5:0] s_cs;
    logic [6:0] p_cs;
    logic [8:0] cyc;
    logic [9:0] exp_len;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 6'd1,       7'd6,       6'd1,       7'd6,       9'd7,           10'd7},
    '{1'b0, 1'b1, 6'd2,       7'd3,       6'd0,       7'd8,       9'd10,          10'd10},
    '{1'b0, 1'b0, 6'd2,       7'd3,       6'd0,       7'd8,       9'd10,          10'd10},
    '{1'b1, 1'b0, 6'd2,       7'd2,       6'd1,       7'd5,       9'd9,           10'd9},
    '{1'b1, 1'b1, 6'd2,       7'd2,       6'd1,       7'd5,       9'd9,           10'd9},
    '{1'b0, 1'b0, 6'b100001,  7'b1000001, 6'b100000,  7'b1000010, 9'b10_0000000,  10'd512},
    '{1'b1, 1'b1, 6'd5,       7'd30,      6'd3,       7'd40,      9'b01_0000101,  10'd261}
  };

  function automatic int dec_s(input logic [5:0] c);
    return int'(c[5]) * 128 + int'(c[4:0]);
  endfunction
  function automatic int dec_p(input logic [6:0] c);
    return int'(c[6]) * 256 + int'(c[5:0]);
  endfunction
  function automatic int dec_c(input logic [8:0] c);
    return int'(c[8:7]) * 256 + int'(c[6:0]);
  endfunction
  function automatic logic [DATA_W-1:0] bus_val(input int k);
    return DATA_W'(16'h5A00 + k);
  endfunction

  task automatic load_vec(input vec_t v);
    we_s = 6'd0; csw_s = 6'd0; rd_s = 6'd0; csr_s = 6'd0;
    we_p = 7'd1; csw_p = 7'd1; rd_p = 7'd1; csr_p = 7'd1;
    if (v.wr) begin
      we_s = v.s_str; we_p = v.p_str; csw_s = v.s_cs; csw_p = v.p_cs;
      wr_on_cs = v.mode; rd_on_cs = 1'b0;
    end else begin
      rd_s = v.s_str; rd_p = v.p_str; csr_s = v.s_cs; csr_p = v.p_cs;
      rd_on_cs = v.mode; wr_on_cs = 1'b0;
    end
    cyc = v.cyc;
  endtask

  task automatic run_access(input vec_t v, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] wd, input bit poke);
    int k = 0;
    int cs_first = -1, cs_cnt = 0, st_first = -1, st_cnt = 0, other_cnt = 0;
    int oe_cnt = 0, dq_bad = 0, addr_bad = 0, rdy_bad = 0;
    int exp_len, s_str, s_cs, p_str, p_cs, cap_k;
    logic st_n, ot_n;
    load_vec(v);
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && k < 2000) begin
      st_n = v.wr ? mem_wr_n : mem_rd_n;
      ot_n = v.wr ? mem_rd_n : mem_wr_n;
      if (!mem_cs_n) begin if (cs_first < 0) cs_first = k; cs_cnt++; end
      if (!st_n)     begin if (st_first < 0) st_first = k; st_cnt++; end
      if (!ot_n) other_cnt++;
      if (mem_dout_oe) begin oe_cnt++; if (mem_dout != wd) dq_bad++; end
      if (mem_addr != a) addr_bad++;
      if (req_ready) rdy_bad++;
      mem_din = bus_val(k);
      if (poke && k >= 2) begin
        req_valid = 1'b1; req_addr = ~a; req_wdata = ~wd;
      end
      k++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    exp_len = dec_c(v.cyc);
    s_str = dec_s(v.s_str); p_str = dec_p(v.p_str);
    s_cs  = dec_s(v.s_cs);  p_cs  = dec_p(v.p_cs);
    chk("R4 length table", exp_len, int'(v.exp_len));
    chk("R4 busy length", k, exp_len);
    chk("R2 cs first low", cs_first, s_cs);
    chk("R3 cs low count", cs_cnt, p_cs);
    chk("R2 strobe first low", st_first, s_str);
    chk("R3 strobe low count", st_cnt, p_str);
    chk("R9 other strobe low", other_cnt, 0);
    chk("R10 address stable", addr_bad, 0);
    chk("R10 ready low while busy", rdy_bad, 0);
    if (v.wr) begin
      chk("R8 write enable cycles", oe_cnt, v.mode ? p_cs : p_str);
      chk("R8 write data value", dq_bad, 0);
    end else begin
      cap_k = v.mode ? (s_cs + p_cs - 1) : (s_str + p_str - 1);
      chk("R7 read data", int'(rsp_rdata), int'(bus_val(cap_k)));
      chk("R8 no write enable on read", oe_cnt, 0);
    end
    @(negedge clk);
    chk("R4 done single cycle", int'(rsp_done), 0);
    chk("R4 ready after done", int'(req_ready), 1);
    if (poke) chk("R10 ignored request left bus idle", int'(mem_cs_n), 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int idle_cs;
    int seen_done;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; mem_din = '0;
    load_vec(VECS[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs idle", int'(mem_cs_n), 1);
    chk("R1 rd idle", int'(mem_rd_n), 1);
    chk("R1 wr idle", int'(mem_wr_n), 1);
    chk("R1 oe idle", int'(mem_dout_oe), 0);
    chk("R1 done idle", int'(rsp_done), 0);
    chk("R1 ready", int'(req_ready), 1);

    for (int i = 0; i < NV; i++)
      run_access(VECS[i], ADDR_W'(16'h1230 + i), DATA_W'(16'hBEE0 + i), 1'b0);

    // R10: request held during busy
    run_access(VECS[1], 16'h0F0F, 16'h0000, 1'b1);

    // R5: zero width on an unused lane
    load_vec(VECS[0]);
    we_p = 7'd0;
    @(negedge clk);
    chk("R5 error flag", int'(cfg_err), 1);
    chk("R5 ready low", int'(req_ready), 0);
    req_valid = 1'b1; req_write = 1'b0;
    idle_cs = 0; seen_done = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (!mem_cs_n || !mem_rd_n) idle_cs++;
      if (rsp_done) seen_done++;
    end
    req_valid = 1'b0;
    chk("R5 no bus activity", idle_cs, 0);
    chk("R5 no completion", seen_done, 0);

    // R6: lane exceeds the length, then exactly fits it
    load_vec(VECS[0]);
    cyc = 9'd6;
    @(negedge clk);
    chk("R6 overrun flagged", int'(cfg_err), 1);
    req_valid = 1'b1;
    idle_cs = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (!mem_cs_n) idle_cs++;
    end
    req_valid = 1'b0;
    chk("R6 no access started", idle_cs, 0);
    cyc = 9'd7;
    @(negedge clk);
    chk("R6 exact fit legal", int'(cfg_err), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule